// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer with Baud Strobe

This block is a 16-bit timer/counter held as two 8-bit halves. It has a 16-bit reload register that also serves as a capture register, and an external trigger input. Its clock source is one of three: a machine-cycle tick, a state-time tick, or falling edges on an external count pin. Both pins are sampled once per machine-cycle tick. Software sets the mode, loads the count and the reload value, and clears the flags through a single-cycle register-write port.

There are three modes. Capture mode is a plain 16-bit counter, and a trigger edge can optionally snapshot the count into the reload register. Auto-reload mode reloads on overflow, and the trigger pin can either force a reload or set the count direction. Baud mode counts on the state-time tick and emits a one-cycle strobe on each overflow. Interrupt arbitration, the serial channel and bus decoding live outside the block.

Top module: `trig_timer16`

## Requirements
- R1: After reset, the count, the reload register, both flags and the baud strobe are all zero. The down-count enable is also zero, so counting defaults to up.
- R2: In timer function (control bit1 = 0, not baud), the count advances by one on each clock edge that has `mc_tick` high. When the run bit (control bit0) is 0, the count holds its value.
- R3: In counter function (control bit1 = 1), `cnt_pin` is sampled on each `mc_tick`. The count advances on the tick where the previous sample was 1 and the pin is now 0. Pin activity between ticks has no effect.
- R4: In capture mode (control bit3 = 0), counting up from 0xFFFF gives 0x0000 and sets the overflow flag.
- R5: In capture mode with external enable (control bit2) set, a trigger falling edge copies the pre-increment count into the reload register and sets the external flag. With external enable clear, the same edge changes neither.
- R6: In auto-reload mode (control bit3 = 1), counting up from 0xFFFF loads the reload value and sets the overflow flag.
- R7: In auto-reload mode with external enable set and down-count enable clear, a trigger falling edge while running loads the reload value and sets the external flag. It leaves the overflow flag unchanged.
- R8: In auto-reload mode with down-count enable (mode register bit0) set, `trg_pin` high selects up-counting and low selects down-counting. A down count taken while the count equals the reload value loads 0xFFFF and sets the overflow flag.
- R9: Setting either baud bit (control bit4 or bit5) switches the count source from `mc_tick` to `st_tick`. In this mode an overflow loads the reload value and pulses `baud_strobe` for one cycle, and never sets the overflow flag. A trigger edge with external enable set only sets the external flag.
- R10: Both flags stay set until a write to register 6 clears them: data bit0 clears the overflow flag and bit1 clears the external flag.
- R11: Register addresses are: 0 control, 1 mode, 2 count low byte, 3 count high byte, 4 reload low byte, 5 reload high byte, 6 flag clear. A byte write changes only its own half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle enable (one clock in 12) |
| st_tick | input | 1 | State-time enable (one clock in 2) |
| cnt_pin | input | 1 | External count input |
| trg_pin | input | 1 | External trigger / direction input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| count_q | output | 16 | Current count |
| rld_q | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| baud_strobe | output | 1 | One-cycle baud overflow pulse |

## Verification
Some properties are checked on every cycle:
- a stopped counter never moves;
- a capture copies the previous count;
- an enabled trigger edge always raises the external flag;
- a down-count wrap lands on 0xFFFF;
- the baud strobe appears only in baud mode, and that mode never raises the overflow flag;
- flags stay set until cleared.

Other behaviour can only be shown by bench scenarios:
- the pin sampling rule, where a fall must span two ticks;
- the difference in tick source between the modes;
- the choice between reload and clear-to-zero on overflow;
- the direction taken from the trigger level;
- long random runs of counter-mode edges and captures compared against a bench model.

// File: rtl/trt_pkg.sv
package trt_pkg;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_MODE   = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_RLD_LO = 3'd4,
    REG_RLD_HI = 3'd5,
    REG_FLAGS  = 3'd6
  } reg_sel_e;

  // control register, bit5 down to bit0
  typedef struct packed {
    logic rx_baud;
    logic tx_baud;
    logic reload_mode;
    logic ext_en;
    logic count_pin;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/trt_fall_det.sv
module trt_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    smp_q <= 1'b0;
    else if (tick) smp_q <= pin;
  end

  // previous tick saw high, this tick sees low
  assign fall = tick & smp_q & ~pin;
endmodule

// File: rtl/trt_ctrl_regs.sv
module trt_ctrl_regs
  import trt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [5:0]    cfg_data,
  output ctrl_t         ctrl,
  output logic          down_en,
  output logic          cnt_lo_wr,
  output logic          cnt_hi_wr,
  output logic          rld_lo_wr,
  output logic          rld_hi_wr,
  output logic          clr_ovf,
  output logic          clr_ext
);
  logic ctrl_wr, mode_wr, flag_wr;

  always_comb begin
    ctrl_wr = 1'b0; mode_wr = 1'b0; flag_wr = 1'b0;
    cnt_lo_wr = 1'b0; cnt_hi_wr = 1'b0; rld_lo_wr = 1'b0; rld_hi_wr = 1'b0;
    if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_CTRL:   ctrl_wr   = 1'b1;
        REG_MODE:   mode_wr   = 1'b1;
        REG_CNT_LO: cnt_lo_wr = 1'b1;
        REG_CNT_HI: cnt_hi_wr = 1'b1;
        REG_RLD_LO: rld_lo_wr = 1'b1;
        REG_RLD_HI: rld_hi_wr = 1'b1;
        REG_FLAGS:  flag_wr   = 1'b1;
        default: ;
      endcase
    end
  end

  assign clr_ovf = flag_wr & cfg_data[0];
  assign clr_ext = flag_wr & cfg_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      down_en <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl    <= ctrl_t'(cfg_data);
      if (mode_wr) down_en <= cfg_data[0];
    end
  end
endmodule

// File: rtl/trt_core.sv
module trt_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic           trig_fall,
  input  logic           ext_en,
  input  logic           dir_up,
  input  logic           baud_mode,
  input  logic           reload_mode,
  input  logic           down_en,
  input  logic           run,
  input  logic           cnt_lo_wr,
  input  logic           cnt_hi_wr,
  input  logic           rld_lo_wr,
  input  logic           rld_hi_wr,
  input  logic           clr_ovf,
  input  logic           clr_ext,
  input  logic [W/2-1:0] wr_data,
  output logic [W-1:0]   count_q,
  output logic [W-1:0]   rld_q,
  output logic           ovf_flag,
  output logic           ext_flag,
  output logic           baud_strobe,
  output logic           dn_wrap,
  output logic           trig_reload
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] put_half(input logic [W-1:0] v, input logic hi,
                                            input logic [HALF-1:0] d);
    logic [W-1:0] r;
    r = v;
    if (hi) r[W-1:HALF] = d;
    else    r[HALF-1:0] = d;
    return r;
  endfunction

  function automatic logic [W-1:0] step_cnt(input logic [W-1:0] v, input logic down);
    return down ? v - ONE : v + ONE;
  endfunction

  logic go_down, up_wrap, trig_act, trig_capture, ovf_set;
  logic [W-1:0] cnt_nxt, rld_nxt;

  assign go_down      = reload_mode & ~baud_mode & ~dir_up;
  assign up_wrap      = inc & ~go_down & (count_q == TOP);
  assign dn_wrap      = inc & go_down & (count_q == rld_q);
  assign trig_act     = trig_fall & ext_en;
  assign trig_reload  = trig_act & run & reload_mode & ~baud_mode & ~down_en;
  assign trig_capture = trig_act & ~reload_mode & ~baud_mode;
  assign ovf_set      = (up_wrap | dn_wrap) & ~baud_mode;

  always_comb begin
    cnt_nxt = count_q;
    if (trig_reload)  cnt_nxt = rld_q;
    else if (up_wrap) cnt_nxt = (reload_mode | baud_mode) ? rld_q : '0;
    else if (dn_wrap) cnt_nxt = TOP;
    else if (inc)     cnt_nxt = step_cnt(count_q, go_down);
    if (cnt_lo_wr) cnt_nxt = put_half(cnt_nxt, 1'b0, wr_data);
    if (cnt_hi_wr) cnt_nxt = put_half(cnt_nxt, 1'b1, wr_data);

    rld_nxt = trig_capture ? count_q : rld_q;
    if (rld_lo_wr) rld_nxt = put_half(rld_nxt, 1'b0, wr_data);
    if (rld_hi_wr) rld_nxt = put_half(rld_nxt, 1'b1, wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q     <= '0;
      rld_q       <= '0;
      ovf_flag    <= 1'b0;
      ext_flag    <= 1'b0;
      baud_strobe <= 1'b0;
    end else begin
      count_q     <= cnt_nxt;
      rld_q       <= rld_nxt;
      ovf_flag    <= ovf_set  | (ovf_flag & ~clr_ovf);
      ext_flag    <= trig_act | (ext_flag & ~clr_ext);
      baud_strobe <= up_wrap & baud_mode;
    end
  end
endmodule

// File: rtl/trig_timer16.sv
module trig_timer16
  import trt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_tick,
  input  logic          st_tick,
  input  logic          cnt_pin,
  input  logic          trg_pin,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W/2-1:0] wr_data,
  output logic [W-1:0]  count_q,
  output logic [W-1:0]  rld_q,
  output logic          ovf_flag,
  output logic          ext_flag,
  output logic          baud_strobe
);
  ctrl_t ctrl;
  logic down_en, cnt_lo_wr, cnt_hi_wr, rld_lo_wr, rld_hi_wr, clr_ovf, clr_ext;
  logic cnt_fall, trig_fall;
  logic run, ext_en, reload_mode, baud_mode, dir_up, tick_src, inc;
  logic cnt_wr, rld_wr, dn_wrap, trig_reload;

  trt_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cfg_data(wr_data[5:0]), .ctrl(ctrl), .down_en(down_en),
    .cnt_lo_wr(cnt_lo_wr), .cnt_hi_wr(cnt_hi_wr),
    .rld_lo_wr(rld_lo_wr), .rld_hi_wr(rld_hi_wr),
    .clr_ovf(clr_ovf), .clr_ext(clr_ext)
  );

  trt_fall_det u_cnt_det (.clk(clk), .rst_n(rst_n), .tick(mc_tick), .pin(cnt_pin), .fall(cnt_fall));
  trt_fall_det u_trg_det (.clk(clk), .rst_n(rst_n), .tick(mc_tick), .pin(trg_pin), .fall(trig_fall));

  assign run         = ctrl.run;
  assign ext_en      = ctrl.ext_en;
  assign reload_mode = ctrl.reload_mode;
  assign baud_mode   = ctrl.tx_baud | ctrl.rx_baud;
  assign dir_up      = ~down_en | trg_pin;
  assign tick_src    = baud_mode ? st_tick : mc_tick;
  assign inc         = run & (ctrl.count_pin ? cnt_fall : tick_src);
  assign cnt_wr      = cnt_lo_wr | cnt_hi_wr;
  assign rld_wr      = rld_lo_wr | rld_hi_wr;

  trt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(inc), .trig_fall(trig_fall), .ext_en(ext_en),
    .dir_up(dir_up), .baud_mode(baud_mode), .reload_mode(reload_mode),
    .down_en(down_en), .run(run),
    .cnt_lo_wr(cnt_lo_wr), .cnt_hi_wr(cnt_hi_wr),
    .rld_lo_wr(rld_lo_wr), .rld_hi_wr(rld_hi_wr),
    .clr_ovf(clr_ovf), .clr_ext(clr_ext), .wr_data(wr_data),
    .count_q(count_q), .rld_q(rld_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .baud_strobe(baud_strobe), .dn_wrap(dn_wrap), .trig_reload(trig_reload)
  );
endmodule

// File: rtl/trt_checker.sv
module trt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         cnt_wr,
  input logic         rld_wr,
  input logic         baud_mode,
  input logic         reload_mode,
  input logic         ext_en,
  input logic         trig_fall,
  input logic         dn_wrap,
  input logic         clr_ovf,
  input logic [W-1:0] count_q,
  input logic [W-1:0] rld_q,
  input logic         ovf_flag,
  input logic         ext_flag,
  input logic         baud_strobe
);
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count_q)); // R2

  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && ext_en && !reload_mode && !baud_mode && !rld_wr) |=> (rld_q == $past(count_q))); // R5

  AST_EXT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && ext_en) |=> ext_flag); // R5

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_wrap && !cnt_wr) |=> (count_q == '1)); // R8

  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_mode && !ovf_flag) |=> !ovf_flag); // R9

  AST_STROBE_BAUD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    baud_strobe |-> $past(baud_mode)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag); // R10
endmodule

bind trig_timer16 trt_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_wr(cnt_wr), .rld_wr(rld_wr),
  .baud_mode(baud_mode), .reload_mode(reload_mode), .ext_en(ext_en),
  .trig_fall(trig_fall), .dn_wrap(dn_wrap), .clr_ovf(clr_ovf),
  .count_q(count_q), .rld_q(rld_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
  .baud_strobe(baud_strobe)
);

// File: tb/trig_timer16_bench.sv
module trig_timer16_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mc_tick = 0, st_tick = 0, cnt_pin = 0, trg_pin = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] count_q, rld_q;
  logic ovf_flag, ext_flag, baud_strobe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_timer16 u_trig_timer16 (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .st_tick(st_tick),
    .cnt_pin(cnt_pin), .trg_pin(trg_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_q(count_q), .rld_q(rld_q), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .baud_strobe(baud_strobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic mc, input logic st);
    mc_tick = mc; st_tick = st;
    @(posedge clk); #2;
    mc_tick = 0; st_tick = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd3, v[15:8]); wr(3'd2, v[7:0]);
  endtask

  task automatic set_rld(input logic [15:0] v);
    wr(3'd5, v[15:8]); wr(3'd4, v[7:0]);
  endtask

  function automatic logic [15:0] plus1(input logic [15:0] v);
    return (v == 16'hFFFF) ? 16'h0000 : v + 16'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] m_cnt, m_rld;
    logic m_ovf, m_ext, m_cs, m_ts;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    chk("R1 count", count_q, 0); chk("R1 reload", rld_q, 0);
    chk("R1 ovf", ovf_flag, 0); chk("R1 ext", ext_flag, 0); chk("R1 strobe", baud_strobe, 0);

    // R2 timer function and run gating
    wr(3'd0, 8'h01);
    for (int i = 0; i < 5; i++) begin step(1, 0); step(0, 0); end
    chk("R2 count after 5 ticks", count_q, 5);
    wr(3'd0, 8'h00);
    for (int i = 0; i < 3; i++) step(1, 0);
    chk("R2 frozen when stopped", count_q, 5);

    // R3 counter function
    set_cnt(16'h0000);
    wr(3'd0, 8'h03);
    cnt_pin = 1; step(1, 0);
    cnt_pin = 0; step(0, 0); step(1, 0); step(1, 0);
    chk("R3 one fall counted", count_q, 1);
    cnt_pin = 1; step(0, 0); cnt_pin = 0; step(0, 0);
    chk("R3 untick toggle ignored", count_q, 1);

    // R4 capture-mode overflow
    wr(3'd0, 8'h01);
    set_cnt(16'hFFFE);
    step(1, 0);
    chk("R4 count FFFF", count_q, 16'hFFFF); chk("R4 no ovf yet", ovf_flag, 0);
    step(1, 0);
    chk("R4 wrap to zero", count_q, 0); chk("R4 ovf set", ovf_flag, 1);

    // R10 sticky then cleared
    step(1, 0); step(0, 0);
    chk("R10 ovf sticky", ovf_flag, 1);
    wr(3'd6, 8'h01);
    chk("R10 ovf cleared", ovf_flag, 0);

    // R11 byte writes, R5 capture
    set_cnt(16'h1234);
    chk("R11 count halves", count_q, 16'h1234);
    wr(3'd0, 8'h05);
    trg_pin = 1; step(1, 0);
    trg_pin = 0; step(1, 0);
    chk("R5 captured", rld_q, 16'h1235); chk("R5 count", count_q, 16'h1236);
    chk("R5 ext set", ext_flag, 1);
    wr(3'd6, 8'h02); wr(3'd0, 8'h01);
    trg_pin = 1; step(1, 0); trg_pin = 0; step(1, 0);
    chk("R5 no capture when disabled", rld_q, 16'h1235);
    chk("R5 no ext when disabled", ext_flag, 0);

    // R6 auto-reload up
    wr(3'd0, 8'h09);
    set_rld(16'h4000); set_cnt(16'hFFFF);
    chk("R11 reload halves", rld_q, 16'h4000);
    step(1, 0);
    chk("R6 reloaded", count_q, 16'h4000); chk("R6 ovf", ovf_flag, 1);
    wr(3'd6, 8'h01);

    // R7 trigger reload
    wr(3'd0, 8'h0D);
    set_cnt(16'h0100);
    trg_pin = 1; step(1, 0);
    trg_pin = 0; step(1, 0);
    chk("R7 trigger reload", count_q, 16'h4000);
    chk("R7 ext set", ext_flag, 1); chk("R7 ovf untouched", ovf_flag, 0);
    wr(3'd6, 8'h03);

    // R8 down counting by trigger level
    wr(3'd1, 8'h01); wr(3'd0, 8'h09);
    set_cnt(16'h4001);
    step(1, 0);
    chk("R8 down count", count_q, 16'h4000);
    step(1, 0);
    chk("R8 underflow to FFFF", count_q, 16'hFFFF); chk("R8 ovf", ovf_flag, 1);
    wr(3'd6, 8'h01);
    trg_pin = 1; step(1, 0);
    chk("R8 level high counts up", count_q, 16'h4000); chk("R8 up ovf", ovf_flag, 1);
    wr(3'd1, 8'h00); wr(3'd6, 8'h03);

    // R9 baud mode
    wr(3'd0, 8'h11);
    set_rld(16'hFFF0); set_cnt(16'hFFFE);
    step(1, 0);
    chk("R9 mc tick ignored", count_q, 16'hFFFE);
    step(0, 1);
    chk("R9 state tick counts", count_q, 16'hFFFF);
    step(0, 1);
    chk("R9 reload", count_q, 16'hFFF0); chk("R9 strobe", baud_strobe, 1);
    chk("R9 ovf untouched", ovf_flag, 0);
    step(0, 0);
    chk("R9 strobe one cycle", baud_strobe, 0);
    wr(3'd0, 8'h21);
    set_cnt(16'hFFFF);
    step(0, 1);
    chk("R9 rx strobe", baud_strobe, 1); chk("R9 rx reload", count_q, 16'hFFF0);
    wr(3'd0, 8'h25);
    set_cnt(16'h0010);
    trg_pin = 0; step(1, 0);
    chk("R9 trigger ext", ext_flag, 1); chk("R9 trigger no reload", count_q, 16'h0010);
    chk("R9 trigger no capture", rld_q, 16'hFFF0); chk("R9 trigger no ovf", ovf_flag, 0);

    // R3/R4/R5 random counter-mode run against model
    wr(3'd0, 8'h00); wr(3'd6, 8'h03);
    set_rld(16'h0000); set_cnt(16'hFFF0);
    cnt_pin = 0; trg_pin = 0; step(1, 0);
    wr(3'd0, 8'h07);
    m_cnt = 16'hFFF0; m_rld = 0; m_ovf = 0; m_ext = 0; m_cs = 0; m_ts = 0;
    for (int i = 0; i < 400; i++) begin
      logic mc, cf, tf;
      mc = 1'($urandom % 2);
      cnt_pin = 1'($urandom % 2);
      trg_pin = ($urandom % 4 == 0) ? ~trg_pin : trg_pin;
      cf = mc & m_cs & ~cnt_pin;
      tf = mc & m_ts & ~trg_pin;
      if (tf) begin m_rld = m_cnt; m_ext = 1; end
      if (cf) begin if (m_cnt == 16'hFFFF) m_ovf = 1; m_cnt = plus1(m_cnt); end
      if (mc) begin m_cs = cnt_pin; m_ts = trg_pin; end
      step(mc, 0);
      chk("R3 random count", count_q, m_cnt);
      chk("R5 random capture", rld_q, m_rld);
      if (i % 50 == 49) begin
        chk("R4 random ovf", ovf_flag, m_ovf);
        chk("R5 random ext", ext_flag, m_ext);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule